// File: doc/BRIEF.md
# Programmable Local Bus Strobe Sequencer

The sequencer drives the active-low control strobes of a single read or write access on an 8-bit or 32-bit local bus. A host writes one 32-bit timing word. Its 4-bit fields place each strobe edge at its own cycle offset, and every offset counts from a common reference cycle. The reference cycle is the cycle after an accepted start pulse. The same fields apply to both bus widths.

A mode input picks one of two pin styles:
- **Separate-strobe style:** the block drives a read strobe, a write strobe and four chip-selects.
- **Direction-plus-strobe style:** the block drives a read-not-write level and four byte data strobes.

The block captures the timing word, mode, direction and byte enables when it accepts a start. While the access runs it holds `busy_o` high. It ends the access with a one-cycle `done_o` pulse.

Top module: `lbus_strobe_seq`

## Requirements
- R1: Out of reset, and whenever the block is idle, every strobe output (`cs_n_o`, `rd_n_o`, `wr_n_o`, `ds_n_o`) is high and `rnw_o` is high. `busy_o` and `done_o` are low.
- R2: A `start_i` high while idle is accepted at the clock edge. In the next cycle `busy_o` is high, and that cycle is offset 0, the reference cycle. Each later cycle adds one to the offset.
- R3: In separate-strobe mode (`mode_dir_i`=0), a read holds `rd_n_o` low exactly for offsets c with RA <= c < RD. RA is `timing_i[19:16]` and RD is `timing_i[23:20]`. `wr_n_o` stays high during a read.
- R4: In separate-strobe mode, a write holds `wr_n_o` low exactly for offsets WA <= c < WD. WA is `timing_i[27:24]` and WD is `timing_i[31:28]`. `rd_n_o` stays high during a write.
- R5: In separate-strobe mode, `cs_n_o[i]` is low for offsets c < CD only on lanes where `byte_en_i[i]`=1. For a write, CD is `timing_i[15:12]`; for a read, CD is RD.
- R6: In direction-plus-strobe mode (`mode_dir_i`=1), `ds_n_o[i]` is low on enabled lanes over the read window (R3) or the write window (R4). In this mode `rd_n_o`, `wr_n_o` and `cs_n_o` stay high. In separate-strobe mode `ds_n_o` stays high.
- R7: In direction-plus-strobe mode, `rnw_o` stays high for a read. For a write it is low for offsets c < `timing_i[15:12]` and high after that.
- R8: `done_o` pulses for one cycle at offset E, and `busy_o` is low in the next cycle. E is RD for a read and max(`timing_i[15:12]`, WD) for a write. E = 0 gives a one-cycle access.
- R9: A timing field above 10 acts as 10.
- R10: A strobe whose assert offset is greater than or equal to its de-assert offset never goes low during the access.
- R11: A `start_i` while busy is ignored. The timing word, mode, direction and byte enables are sampled only at acceptance, so changes during an access have no effect on it.
- R12: `timing_i[11:0]` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for one access |
| is_read_i | input | 1 | 1 = read access, 0 = write access |
| mode_dir_i | input | 1 | 0 = separate strobes, 1 = direction plus data strobes |
| byte_en_i | input | 4 | Byte lane enables |
| timing_i | input | 32 | Host-written timing word |
| cs_n_o | output | 4 | Chip-selects, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| rnw_o | output | 1 | Read-not-write level |
| ds_n_o | output | 4 | Byte data strobes, active low |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle end-of-access pulse |

## Verification
The bench issues reads and writes in both pin styles using the two reset presets. Comparing these cases separates the read window from the write window, and the chip-select end from the data-strobe end. Further cases each isolate one behaviour:
- a write whose chip-select ends before the write strobe does, and a direction-plus-strobe write whose direction level rises while the data strobes are still low, which prove that the end offset takes the larger de-assert;
- sparse byte enables, which expose lane mapping;
- reserved field values, which show the clamp;
- an inverted window, which shows suppression;
- a zero-length access;
- a restart and an input change mid-access, which show that the configuration is latched;
- a configuration that differs only in the low unused timing bits.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  localparam int OFF_W   = 4;
  localparam int OFF_MAX = 10;
  localparam int LANES   = 4;

  typedef logic [OFF_W-1:0] off_t;

  typedef struct packed {
    off_t wr_de;
    off_t wr_as;
    off_t rd_de;
    off_t rd_as;
    off_t cs_wr_de;
  } lbs_tim_t;

  typedef struct packed {
    lbs_tim_t         tim;
    logic             is_read;
    logic             mode_dir;
    logic [LANES-1:0] be;
  } lbs_cfg_t;

  function automatic off_t clamp_off(input off_t v);
    return (int'(v) > OFF_MAX) ? off_t'(OFF_MAX) : v;
  endfunction

  function automatic logic in_window(input off_t c, input off_t a, input off_t d);
    return (c >= a) && (c < d);
  endfunction

  function automatic off_t max_off(input off_t a, input off_t b);
    return (a > b) ? a : b;
  endfunction

  function automatic off_t end_off(input lbs_tim_t t, input logic is_read);
    return is_read ? t.rd_de : max_off(t.cs_wr_de, t.wr_de);
  endfunction
endpackage

// File: rtl/lbs_timing_decode.sv
module lbs_timing_decode
  import lbs_pkg::*;
#(
  parameter int CS_LSB  = 12,
  parameter int RAS_LSB = 16,
  parameter int RDE_LSB = 20,
  parameter int WAS_LSB = 24,
  parameter int WDE_LSB = 28
) (
  input  logic [31:0] reg_i,
  output lbs_tim_t    tim_o
);
  localparam int NF = 5;
  localparam int LSBS [NF] = '{CS_LSB, RAS_LSB, RDE_LSB, WAS_LSB, WDE_LSB};

  off_t raw  [NF];
  off_t clmp [NF];
  logic [NF-1:0] clamp_evt;
  logic unused_low;

  assign unused_low = ^reg_i[CS_LSB-1:0];

  for (genvar f = 0; f < NF; f++) begin : g_field
    assign raw[f]       = reg_i[LSBS[f] +: OFF_W];
    assign clmp[f]      = clamp_off(raw[f]);
    assign clamp_evt[f] = (raw[f] != clmp[f]);
  end

  assign tim_o.cs_wr_de = clmp[0];
  assign tim_o.rd_as    = clmp[1];
  assign tim_o.rd_de    = clmp[2];
  assign tim_o.wr_as    = clmp[3];
  assign tim_o.wr_de    = clmp[4];

  always_comb begin
    if (clamp_evt[4]) assert_clamp_val_R9: assert (int'(tim_o.wr_de) == OFF_MAX);
    if (clamp_evt[2]) assert_clamp_rd_R9: assert (int'(tim_o.rd_de) == OFF_MAX);
  end
endmodule

// File: rtl/lbs_cycle_ctr.sv
module lbs_cycle_ctr
  import lbs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  off_t end_off_i,
  output logic accept_o,
  output logic busy_o,
  output off_t cnt_o,
  output logic done_o
);
  logic busy_q;
  off_t cnt_q;

  assign accept_o = start_i && !busy_q;
  assign done_o   = busy_q && (cnt_q == end_off_i);
  assign busy_o   = busy_q;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (done_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assert_start_ref_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> (busy_q && cnt_q == '0));
  assert_done_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_q);
  assert_cnt_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (int'(cnt_q) <= OFF_MAX));
  assert_restart_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_q && !done_o) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/lbs_pin_map.sv
module lbs_pin_map
  import lbs_pkg::*;
(
  input  logic             busy_i,
  input  off_t             cnt_i,
  input  lbs_cfg_t         cfg_i,
  output logic [LANES-1:0] cs_n_o,
  output logic             rd_n_o,
  output logic             wr_n_o,
  output logic             rnw_o,
  output logic [LANES-1:0] ds_n_o
);
  logic rd_win, wr_win, cs_win, dir_low, sep_mode;
  off_t cs_de;

  assign sep_mode = !cfg_i.mode_dir;
  assign rd_win   = busy_i && cfg_i.is_read  && in_window(cnt_i, cfg_i.tim.rd_as, cfg_i.tim.rd_de);
  assign wr_win   = busy_i && !cfg_i.is_read && in_window(cnt_i, cfg_i.tim.wr_as, cfg_i.tim.wr_de);
  assign cs_de    = cfg_i.is_read ? cfg_i.tim.rd_de : cfg_i.tim.cs_wr_de;
  assign cs_win   = busy_i && in_window(cnt_i, '0, cs_de);
  assign dir_low  = busy_i && cfg_i.mode_dir && !cfg_i.is_read && (cnt_i < cfg_i.tim.cs_wr_de);

  assign rd_n_o = !(rd_win && sep_mode);
  assign wr_n_o = !(wr_win && sep_mode);
  assign rnw_o  = !dir_low;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign cs_n_o[i] = !(cs_win && sep_mode && cfg_i.be[i]);
    assign ds_n_o[i] = !((rd_win || wr_win) && cfg_i.mode_dir && cfg_i.be[i]);
  end

  always_comb begin
    assert_rw_excl_R3: assert (rd_n_o || wr_n_o);
    if (cfg_i.mode_dir) assert_dir_quiet_R6: assert (rd_n_o && wr_n_o && (&cs_n_o));
    else                assert_sep_quiet_R6: assert (&ds_n_o);
    if (cfg_i.is_read)  assert_rnw_read_R7: assert (rnw_o);
  end
endmodule

// File: rtl/lbus_strobe_seq.sv
module lbus_strobe_seq
  import lbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             is_read_i,
  input  logic             mode_dir_i,
  input  logic [LANES-1:0] byte_en_i,
  input  logic [31:0]      timing_i,
  output logic [LANES-1:0] cs_n_o,
  output logic             rd_n_o,
  output logic             wr_n_o,
  output logic             rnw_o,
  output logic [LANES-1:0] ds_n_o,
  output logic             busy_o,
  output logic             done_o
);
  lbs_tim_t tim_dec;
  lbs_cfg_t cfg_q;
  logic     accept;
  off_t     cnt;
  off_t     end_sel;

  lbs_timing_decode u_dec (
    .reg_i (timing_i),
    .tim_o (tim_dec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (accept) cfg_q <= '{tim: tim_dec, is_read: is_read_i,
                                mode_dir: mode_dir_i, be: byte_en_i};
  end

  assign end_sel = end_off(cfg_q.tim, cfg_q.is_read);

  lbs_cycle_ctr u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .end_off_i (end_sel),
    .accept_o  (accept),
    .busy_o    (busy_o),
    .cnt_o     (cnt),
    .done_o    (done_o)
  );

  lbs_pin_map u_pins (
    .busy_i (busy_o),
    .cnt_i  (cnt),
    .cfg_i  (cfg_q),
    .cs_n_o (cs_n_o),
    .rd_n_o (rd_n_o),
    .wr_n_o (wr_n_o),
    .rnw_o  (rnw_o),
    .ds_n_o (ds_n_o)
  );

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> ((&cs_n_o) && rd_n_o && wr_n_o && rnw_o && (&ds_n_o) && !done_o));
  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !$past(accept)) |-> $stable(cfg_q));
endmodule

// File: tb/sim_lbus_strobe_seq.sv
module sim_lbus_strobe_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, is_read = 1'b0, mode_dir = 1'b0;
  logic [3:0] be = 4'h0;
  logic [31:0] tim = 32'h0;
  logic [3:0] cs_n, ds_n;
  logic rd_n, wr_n, rnw, busy, done;

  int n_tests = 0, n_fail = 0;
  logic [12:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  lbus_strobe_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .is_read_i(is_read),
    .mode_dir_i(mode_dir), .byte_en_i(be), .timing_i(tim),
    .cs_n_o(cs_n), .rd_n_o(rd_n), .wr_n_o(wr_n), .rnw_o(rnw),
    .ds_n_o(ds_n), .busy_o(busy), .done_o(done)
  );

  localparam logic [12:0] IDLE = 13'b1111_1_1_1_1111_0_0;

  function automatic logic [12:0] actual();
    return {cs_n, rd_n, wr_n, rnw, ds_n, busy, done};
  endfunction

  function automatic int lim(input logic [3:0] v);
    return (v > 4'd10) ? 10 : int'(v);
  endfunction

  task automatic check(input string tag, input logic [12:0] got, input logic [12:0] want);
    n_tests++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, want);
    end
  endtask

  // Scoreboard model: one expected vector per access cycle, built from the requirements.
  task automatic push_expected(input bit rd, input bit dir, input logic [3:0] lanes,
                               input logic [31:0] t, input string tag);
    int csd = lim(t[15:12]), ra = lim(t[19:16]), rde = lim(t[23:20]);
    int wa = lim(t[27:24]), wde = lim(t[31:28]);
    int last = rd ? rde : ((csd > wde) ? csd : wde);
    for (int c = 0; c <= last; c++) begin
      bit rd_on  = rd && (c >= ra) && (c < rde);
      bit wr_on  = !rd && (c >= wa) && (c < wde);
      bit sel_on = !dir && (c < (rd ? rde : csd));
      logic [3:0] csv, dsv;
      for (int i = 0; i < 4; i++) begin
        csv[i] = !(sel_on && lanes[i]);
        dsv[i] = !(dir && (rd_on || wr_on) && lanes[i]);
      end
      exp_q.push_back({csv, !(!dir && rd_on), !(!dir && wr_on),
                       !(dir && !rd && c < csd), dsv, 1'b1, (c == last)});
      tag_q.push_back(tag);
    end
  endtask

  task automatic run_access(input bit rd, input bit dir, input logic [3:0] lanes,
                            input logic [31:0] t, input bit poke, input string tag);
    while (exp_q.size() != 0 || busy) @(negedge clk);
    @(negedge clk);
    is_read = rd; mode_dir = dir; be = lanes; tim = t; start = 1'b1;
    push_expected(rd, dir, lanes, t, tag);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      start = 1'b1; is_read = ~rd; mode_dir = ~dir; be = ~lanes; tim = ~t;
      @(negedge clk);
      start = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin : monitor
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() != 0) check(tag_q.pop_front(), actual(), exp_q.pop_front());
      else                   check("R1 idle", actual(), IDLE);
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    #(8 * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin : driver
    #3;
    check("R1 reset", actual(), IDLE);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3 R5 R8: separate-strobe read, default preset
    run_access(1, 0, 4'hF, 32'h2030_2000, 0, "R3 sep read");
    // R4 R5: separate-strobe write, default preset
    run_access(0, 0, 4'hF, 32'h2030_2000, 0, "R4 sep write");
    // R5 R8: chip-select ends before write strobe; sparse lanes
    run_access(0, 0, 4'b0101, 32'h7300_4000, 0, "R5 cs early end");
    // R6: direction-plus-strobe read, parallel preset, lanes 1 and 3
    run_access(1, 1, 4'b1010, 32'h2121_2000, 0, "R6 dir read");
    // R7: direction-plus-strobe write, parallel preset
    run_access(0, 1, 4'hF, 32'h2121_2000, 0, "R7 dir write");
    // R7 R8: direction rises at 4 while data strobes stay low until 6
    run_access(0, 1, 4'b0011, 32'h6200_4000, 0, "R7 dir early rise");
    // R9: reserved values clamp to 10
    run_access(0, 0, 4'hF, 32'hF900_C000, 0, "R9 clamp write");
    run_access(1, 1, 4'b1100, 32'h0FE0_0000, 0, "R9 clamp read");
    // R10: inverted window suppresses the strobe
    run_access(1, 0, 4'hF, 32'h2035_2000, 0, "R10 inverted rd");
    run_access(0, 1, 4'hF, 32'h2500_3000, 0, "R10 inverted ds");
    // R8: zero-length access
    run_access(1, 0, 4'hF, 32'h2000_2000, 0, "R8 zero length");
    // R11: restart and input changes mid-access are ignored
    run_access(0, 0, 4'b0110, 32'h8300_5000, 1, "R11 restart ignored");
    run_access(1, 1, 4'b1001, 32'h2152_3000, 1, "R11 dir latched");
    // R12: low timing bits have no effect
    run_access(1, 0, 4'hF, 32'h2030_2FFF, 0, "R12 low bits");
    run_access(0, 1, 4'b0110, 32'h2121_2ABC, 0, "R12 low bits dir");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule